// File: doc/BRIEF.md
# Pulse Modulation Timing Generator

This block turns a single asynchronous pulse-modulation control level into a modulator drive and a set of leveling-loop gates. A high level on the control input means RF on and a low level means RF off. The drive is steered to one of two band outputs by a band-select input. Four gates are derived from the same RF state:

- a detector sample/hold gate;
- a bias sample/hold gate that works only when its option input is set;
- an ADC enable;
- an integrator gate.

All intervals are counted in cycles of the system clock. The clock frequency is a parameter, and the hold times given in microseconds are turned into cycle counts at elaboration.

The ADC enable is stretched past the end of each pulse. This gives the converter time to read the held detector value before it droops. The integrator gate closes only after RF has been on for a short settle time. Once closed, it stays closed for a minimum time, so that very narrow pulses still give the integrator a useful window.

Top module: `pulse_mod_timing`

## Requirements
- R1: The control input passes through a two-stage synchroniser. A level change made just after clock edge N appears on `detSample` after edge N+3. High means RF on.
- R2: The modulator drive is high only while RF is on. It appears on `lowBandDrive` when `bandLow` is 1 and on `highBandDrive` when `bandLow` is 0. The unselected output is 0. A change of `bandLow` takes effect one clock later.
- R3: `detSample` is 1 (sample) while RF is on and 0 (hold) while RF is off.
- R4: `biasSample` equals `detSample` when `biasEn` was 1 on the previous clock. Otherwise `biasSample` is 0.
- R5: `adcEnable` rises in the same cycle as `detSample`. It stays 1 for exactly ADC_CYC = CLK_HZ/1e6 x ADC_HOLD_US cycles after `detSample` falls (10000 cycles by default), and then drops to 0.
- R6: If RF turns on again while `adcEnable` is in its hold-over, `adcEnable` stays 1 without a gap. The ADC_CYC countdown then restarts from the next fall of `detSample`.
- R7: `intGate` closes (1) SETTLE_CYC cycles after `detSample` rises (2 by default), but only if RF is still on at that point. A pulse seen on `detSample` for fewer than SETTLE_CYC+1 cycles never closes it.
- R8: Once closed, `intGate` stays 1 for at least INT_CYC = CLK_HZ/1e6 x INT_MIN_US cycles (100 by default).
  - A pulse that ends earlier gives a closure of exactly INT_CYC cycles.
  - On a longer pulse, the gate opens in the same cycle that `detSample` falls.
- R9: A synchronous active-high `rst` drives all six outputs to 0 on the next clock. It also clears the synchroniser and all counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulseIn | input | 1 | Asynchronous pulse control level, 1 = RF on |
| bandLow | input | 1 | Band select, 1 = low band |
| biasEn | input | 1 | Enables the bias sample/hold gate |
| lowBandDrive | output | 1 | Modulator drive, low-band path |
| highBandDrive | output | 1 | Modulator drive, high-band path |
| detSample | output | 1 | Detector sample/hold gate, 1 = sample |
| biasSample | output | 1 | Bias sample/hold gate, 1 = sample |
| adcEnable | output | 1 | ADC enable with post-pulse hold-over |
| intGate | output | 1 | Integrator gate, 1 = closed |

## Verification
Every expected edge is scheduled by absolute cycle number at the moment its stimulus is driven:

- A pulse level change shows on `detSample` and on the drive outputs three clocks later.
- A change of band select or bias enable shows one clock later.
- `intGate` rises two clocks after `detSample`.
- `adcEnable` falls ADC_CYC clocks after `detSample` falls.

The bench places each expectation in a time-ordered queue. A monitor compares it on the falling clock edge of exactly that cycle. Boundary values are checked on both sides of each edge: the last cycle still high and the first cycle low. This covers the ADC hold-over, the minimum integrator closure, and the narrowest pulse that closes the integrator gate.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic adcEn;
    logic intClose;
  } ctlStrobes_t;

  function automatic int unsigned usToCycles(input int unsigned hz, input int unsigned us);
    return (hz / 1_000_000) * us;
  endfunction

endpackage

// File: rtl/pmt_control.sv
module pmt_control
  import pmt_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 10_000_000,
  parameter int unsigned ADC_HOLD_US = 1000,
  parameter int unsigned INT_MIN_US  = 10,
  parameter int unsigned SETTLE_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rfOn,
  output ctlStrobes_t ctl
);

  localparam int unsigned ADC_CYC = usToCycles(CLK_HZ, ADC_HOLD_US);
  localparam int unsigned INT_CYC = usToCycles(CLK_HZ, INT_MIN_US);
  localparam int unsigned ADC_W   = $clog2(ADC_CYC + 1);
  localparam int unsigned INT_W   = $clog2(INT_CYC + 1);
  localparam int unsigned SET_W   = $clog2(SETTLE_CYC + 1);

  logic [ADC_W-1:0] adcCnt;
  logic [INT_W-1:0] minCnt;
  logic [SET_W-1:0] settleCnt;
  logic             adcReg;
  logic             intReg;
  logic             stable;

  assign stable = rfOn && (settleCnt == SET_W'(SETTLE_CYC));

  // ADC enable: on with RF, then a fixed hold-over reloaded by each on cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      adcCnt <= '0;
      adcReg <= 1'b0;
    end else if (rfOn) begin
      adcCnt <= ADC_W'(ADC_CYC);
      adcReg <= 1'b1;
    end else if (adcCnt != '0) begin
      adcCnt <= adcCnt - 1'b1;
      adcReg <= 1'b1;
    end else begin
      adcReg <= 1'b0;
    end
  end

  // settle counter: consecutive RF-on cycles, saturating
  always_ff @(posedge clk) begin
    if (rst || !rfOn) begin
      settleCnt <= '0;
    end else if (settleCnt != SET_W'(SETTLE_CYC)) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  // integrator gate with minimum closed time
  always_ff @(posedge clk) begin
    if (rst) begin
      intReg <= 1'b0;
      minCnt <= '0;
    end else if (!intReg) begin
      if (stable) begin
        intReg <= 1'b1;
        minCnt <= INT_W'(INT_CYC - 1);
      end
    end else begin
      if (minCnt != '0) minCnt <= minCnt - 1'b1;
      if (!stable && minCnt == '0) intReg <= 1'b0;
    end
  end

  assign ctl.adcEn    = adcReg;
  assign ctl.intClose = intReg;

endmodule

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pulseIn,
  input  logic        bandLow,
  input  logic        biasEn,
  input  ctlStrobes_t ctl,
  output logic        rfOn,
  output logic        lowBandDrive,
  output logic        highBandDrive,
  output logic        detSample,
  output logic        biasSample,
  output logic        adcEnable,
  output logic        intGate
);

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], pulseIn};
  end

  assign rfOn = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      detSample     <= 1'b0;
      biasSample    <= 1'b0;
      lowBandDrive  <= 1'b0;
      highBandDrive <= 1'b0;
    end else begin
      detSample     <= rfOn;
      biasSample    <= rfOn & biasEn;
      lowBandDrive  <= rfOn & bandLow;
      highBandDrive <= rfOn & ~bandLow;
    end
  end

  assign adcEnable = ctl.adcEn;
  assign intGate   = ctl.intClose;

endmodule

// File: rtl/pulse_mod_timing.sv
module pulse_mod_timing
  import pmt_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 10_000_000,
  parameter int unsigned ADC_HOLD_US = 1000,
  parameter int unsigned INT_MIN_US  = 10,
  parameter int unsigned SETTLE_CYC  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulseIn,
  input  logic bandLow,
  input  logic biasEn,
  output logic lowBandDrive,
  output logic highBandDrive,
  output logic detSample,
  output logic biasSample,
  output logic adcEnable,
  output logic intGate
);

  ctlStrobes_t ctl;
  logic        rfOn;

  pmt_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .bandLow(bandLow), .biasEn(biasEn),
    .ctl(ctl), .rfOn(rfOn), .lowBandDrive(lowBandDrive), .highBandDrive(highBandDrive),
    .detSample(detSample), .biasSample(biasSample), .adcEnable(adcEnable), .intGate(intGate)
  );

  pmt_control #(
    .CLK_HZ(CLK_HZ), .ADC_HOLD_US(ADC_HOLD_US), .INT_MIN_US(INT_MIN_US), .SETTLE_CYC(SETTLE_CYC)
  ) u_ctl (
    .clk(clk), .rst(rst), .rfOn(rfOn), .ctl(ctl)
  );

endmodule

// File: rtl/pulse_mod_timing_chk.sv
module pulse_mod_timing_chk
  import pmt_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 10_000_000,
  parameter int unsigned INT_MIN_US = 10
) (
  input logic clk,
  input logic rst,
  input logic biasEn,
  input logic lowBandDrive,
  input logic highBandDrive,
  input logic detSample,
  input logic biasSample,
  input logic adcEnable,
  input logic intGate
);

  localparam int unsigned INT_CYC = usToCycles(CLK_HZ, INT_MIN_US);

  logic [31:0] highCnt;

  always_ff @(posedge clk) begin
    if (rst || !intGate) highCnt <= '0;
    else if (highCnt != 32'hFFFF_FFFF) highCnt <= highCnt + 1'b1;
  end

  // R2
  drive_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(lowBandDrive && highBandDrive));

  // R4
  bias_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(biasEn) |-> !biasSample);

  // R4
  bias_follow_chk: assert property (@(posedge clk) disable iff (rst)
    biasSample |-> detSample);

  // R5
  adc_cover_chk: assert property (@(posedge clk) disable iff (rst)
    detSample |-> adcEnable);

  // R7
  int_on_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intGate) |-> detSample);

  // R8
  int_min_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(intGate) |-> (highCnt >= INT_CYC));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(lowBandDrive || highBandDrive || detSample || biasSample || adcEnable || intGate));

endmodule

bind pulse_mod_timing pulse_mod_timing_chk #(.CLK_HZ(CLK_HZ), .INT_MIN_US(INT_MIN_US)) u_chk (
  .clk(clk), .rst(rst), .biasEn(biasEn), .lowBandDrive(lowBandDrive),
  .highBandDrive(highBandDrive), .detSample(detSample), .biasSample(biasSample),
  .adcEnable(adcEnable), .intGate(intGate)
);

// File: tb/test_pulse_mod_timing.sv
`timescale 1ns/1ps
module test_pulse_mod_timing;

  localparam int ADC = 10000;
  localparam int INT = 100;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulseIn = 1'b0;
  logic bandLow = 1'b1;
  logic biasEn = 1'b0;
  logic lowBandDrive, highBandDrive, detSample, biasSample, adcEnable, intGate;

  int cyc = 0;
  int testCnt = 0;
  int failCnt = 0;

  typedef struct {
    int    when;
    int    sig;
    bit    val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_mod_timing i_pulse_mod_timing (
    .clk(clk), .rst(rst), .pulseIn(pulseIn), .bandLow(bandLow), .biasEn(biasEn),
    .lowBandDrive(lowBandDrive), .highBandDrive(highBandDrive), .detSample(detSample),
    .biasSample(biasSample), .adcEnable(adcEnable), .intGate(intGate)
  );

  function automatic bit sigVal(input int s);
    case (s)
      0: return lowBandDrive;
      1: return highBandDrive;
      2: return detSample;
      3: return biasSample;
      4: return adcEnable;
      default: return intGate;
    endcase
  endfunction

  function automatic string sigName(input int s);
    case (s)
      0: return "lowBandDrive";
      1: return "highBandDrive";
      2: return "detSample";
      3: return "biasSample";
      4: return "adcEnable";
      default: return "intGate";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  // driver side: schedule an expected value, kept sorted by cycle
  task automatic expectAt(input int when, input int sig, input bit val, input string tag);
    exp_t item;
    int pos;
    item.when = when; item.sig = sig; item.val = val; item.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].when > when) begin pos = i; break; end
    end
    q.insert(pos, item);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].when <= cyc) begin
      exp_t item;
      item = q.pop_front();
      check(item.tag, sigName(item.sig), sigVal(item.sig), item.val);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (q.size() > 0) begin
      failCnt++;
      $display("FAIL queue: actual %0d pending expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int n;
    int f;
    int m;
    // R9: outputs cleared during reset
    step(3);
    for (int s = 0; s < 6; s++) check("R9", sigName(s), sigVal(s), 1'b0);
    rst = 1'b0;
    step(5);
    for (int s = 0; s < 6; s++) check("R9", sigName(s), sigVal(s), 1'b0);

    // long pulse, low band
    pulseIn = 1'b1; n = cyc;
    expectAt(n + LAT - 1, 2, 1'b0, "R1");
    expectAt(n + LAT, 2, 1'b1, "R1");
    expectAt(n + LAT, 0, 1'b1, "R2");
    expectAt(n + LAT, 1, 1'b0, "R2");
    expectAt(n + LAT, 3, 1'b0, "R4");
    expectAt(n + LAT, 4, 1'b1, "R5");
    expectAt(n + LAT + 1, 5, 1'b0, "R7");
    expectAt(n + LAT + 2, 5, 1'b1, "R7");
    expectAt(n + 200, 2, 1'b1, "R3");
    step(300);
    // R2: band switch
    bandLow = 1'b0; m = cyc;
    expectAt(m + 1, 0, 1'b0, "R2");
    expectAt(m + 1, 1, 1'b1, "R2");
    step(10);
    // R4: bias option on, then off
    biasEn = 1'b1; m = cyc;
    expectAt(m, 3, 1'b0, "R4");
    expectAt(m + 1, 3, 1'b1, "R4");
    step(10);
    biasEn = 1'b0; m = cyc;
    expectAt(m + 1, 3, 1'b0, "R4");
    step(10);
    // fall: long pulse opens integrator with detSample, ADC hold-over
    pulseIn = 1'b0; f = cyc;
    expectAt(f + LAT - 1, 5, 1'b1, "R8");
    expectAt(f + LAT, 5, 1'b0, "R8");
    expectAt(f + LAT, 2, 1'b0, "R3");
    expectAt(f + LAT, 1, 1'b0, "R2");
    expectAt(f + LAT + 5, 4, 1'b1, "R5");
    expectAt(f + LAT + ADC - 1, 4, 1'b1, "R5");
    expectAt(f + LAT + ADC, 4, 1'b0, "R5");
    step(ADC + 20);

    // R8: narrow pulse (5 cycles) gets the minimum closure
    bandLow = 1'b1;
    pulseIn = 1'b1; n = cyc;
    step(5);
    pulseIn = 1'b0;
    expectAt(n + LAT + 2, 5, 1'b1, "R7");
    expectAt(n + LAT + 5, 2, 1'b0, "R3");
    expectAt(n + LAT + 2 + INT - 1, 5, 1'b1, "R8");
    expectAt(n + LAT + 2 + INT, 5, 1'b0, "R8");
    step(200);

    // R7: 3-cycle pulse is the shortest that closes the gate
    pulseIn = 1'b1; n = cyc;
    step(3);
    pulseIn = 1'b0;
    expectAt(n + LAT + 2, 5, 1'b1, "R7");
    expectAt(n + LAT + 2 + INT, 5, 1'b0, "R8");
    step(200);

    // R7: 2-cycle pulse never closes it
    pulseIn = 1'b1; n = cyc;
    step(2);
    pulseIn = 1'b0;
    expectAt(n + LAT, 2, 1'b1, "R3");
    for (int k = 1; k <= 6; k++) expectAt(n + LAT + k, 5, 1'b0, "R7");
    step(ADC + 20);

    // R6: re-rise during ADC hold-over
    pulseIn = 1'b1;
    step(20);
    pulseIn = 1'b0; f = cyc;
    step(500);
    pulseIn = 1'b1; n = cyc;
    expectAt(n + LAT - 1, 4, 1'b1, "R6");
    expectAt(n + LAT, 4, 1'b1, "R6");
    step(20);
    pulseIn = 1'b0; m = cyc;
    expectAt(f + LAT + ADC, 4, 1'b1, "R6");
    expectAt(m + LAT + ADC - 1, 4, 1'b1, "R6");
    expectAt(m + LAT + ADC, 4, 1'b0, "R6");
    step(ADC + 20);

    // R9: reset in the middle of a pulse
    pulseIn = 1'b1;
    step(20);
    rst = 1'b1; m = cyc;
    for (int s = 0; s < 6; s++) expectAt(m + 1, s, 1'b0, "R9");
    step(3);
    rst = 1'b0;
    pulseIn = 1'b0;
    step(5);
    finishRun();
  end

endmodule